// File: doc/BRIEF.md
# SAR Conversion Timing Controller

This block sequences one conversion of a 10-bit successive-approximation analog-to-digital converter. A start request latches a 5-bit channel code and a sample-length choice. The controller then drives the channel code to the analog multiplexer. It steps through three phases, and each step happens only on a system clock cycle in which the conversion clock enable is high. The first phase samples through the buffer amplifier. The second samples the input directly. The third resolves the result one bit per enabled cycle.

During resolution the controller presents a trial code to the capacitive DAC and reads the comparator once per bit, starting at the most significant bit. When the last bit is decided, the result appears on a held output together with a one-cycle done pulse. The analog parts sit outside the block: the multiplexer, buffer amplifier, DAC and comparator.

Top module: `sar_conv_seq`

## Requirements
- R1: A start request on a clock with no conversion running is accepted. On the next clock, busy_o is 1, phase_o is 2'b01 (buffered sampling) and ch_sel_o carries the requested channel code.
- R2: The buffered sampling phase (phase_o = 2'b01) lasts exactly 2 enabled conversion-clock cycles.
- R3: The direct sampling phase (phase_o = 2'b10) lasts 2 enabled cycles when long_samp_i was 0 at the start request, and 8 when it was 1.
- R4: The resolution phase (phase_o = 2'b11) lasts 10 enabled cycles and decides the bits from bit 9 down to bit 0. Its first trial code on dac_code_o is 10'h200. Each trial code is the bits kept so far with the current bit set. A trial bit is kept when cmp_i is 1, which means the input is at or above the trial level.
- R5: A whole conversion takes 14 enabled cycles with the short direct sample and 20 with the long one.
- R6: Phase and bit progress only on clocks where conv_en_i is 1. On other clocks the state holds.
- R7: A start request while busy_o is 1 is ignored. The channel, the sample length and the running conversion are unchanged, and no extra result is produced.
- R8: done_o is high for exactly one clock at completion. result_o changes only at that clock and then holds until the next completion.
- R9: Channel codes 0 to 15 select the external inputs. Code 17 selects the low reference, code 18 the high reference and code 19 the midpoint between the two. All of these convert from the comparator.
- R10: Any other channel code (16 and 20 to 31) still runs the full timing, but its result is 0 whatever the comparator reports.
- R11: After reset, phase_o is 2'b00, and busy_o, done_o, result_o and dac_code_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_en_i | input | 1 | Conversion clock enable, one tick per enabled system clock |
| start_i | input | 1 | Conversion start request |
| chan_i | input | 5 | Channel code taken at an accepted start |
| long_samp_i | input | 1 | 1 selects the 8-cycle direct sample, 0 the 2-cycle one |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| ch_sel_o | output | 5 | Channel code presented to the analog multiplexer |
| phase_o | output | 2 | 00 idle, 01 buffered sample, 10 direct sample, 11 resolution |
| dac_code_o | output | 10 | Trial code for the capacitive DAC |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock completion pulse |
| result_o | output | 10 | Last completed result, held |

## Verification
The hardest case is the interplay between a sparse conversion clock enable and the phase boundaries. Phase lengths must be counted in enabled cycles, not system clocks, and a stall on the last cycle of a phase must not skip or repeat that cycle. The bench therefore runs conversions with a gapped enable pattern and with a steady one. It counts enabled cycles per phase, as seen on phase_o at the clock where each tick lands, and compares each count with 2, with 2 or 8, and with 10. A second hard case is a start request arriving mid-conversion. The bench pokes one in during the direct sample phase with a different channel, then checks that the channel output holds and that only one result comes back.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_BUF   = 2'b01,
        PH_FINAL = 2'b10,
        PH_RES   = 2'b11
    } phase_e;

    localparam int CODE_REF_LO  = 17;
    localparam int CODE_REF_HI  = 18;
    localparam int CODE_REF_MID = 19;
endpackage

// File: rtl/sar_chan_decode.sv
module sar_chan_decode #(
    parameter int CHAN_W  = 5,
    parameter int NUM_EXT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CHAN_W-1:0] chan_i,
    output logic [CHAN_W-1:0] ch_sel_o,
    output logic              chan_ok_o
);
    import sar_seq_pkg::*;

    typedef struct packed {
        logic [CHAN_W-1:0] sel;
        logic              ok;
    } dec_t;

    dec_t st_d, st_q;
    logic code_ok;

    always_comb begin
        code_ok = (int'(chan_i) < NUM_EXT)
               || (int'(chan_i) == CODE_REF_LO)
               || (int'(chan_i) == CODE_REF_HI)
               || (int'(chan_i) == CODE_REF_MID);
        st_d = st_q;
        if (load_i) begin
            st_d.sel = chan_i;
            st_d.ok  = code_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_sel_o  = st_q.sel;
    assign chan_ok_o = st_q.ok;
endmodule

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl #(
    parameter int BUF_CYC   = 2,
    parameter int FIN_SHORT = 2,
    parameter int FIN_LONG  = 8,
    parameter int RES_BITS  = 10,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             accept_i,
    input  logic             long_i,
    output sar_seq_pkg::phase_e phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             res_tick_o,
    output logic             finish_o
);
    import sar_seq_pkg::*;

    localparam logic [CNT_W-1:0] BUF_LAST = CNT_W'(BUF_CYC - 1);
    localparam logic [CNT_W-1:0] FS_LAST  = CNT_W'(FIN_SHORT - 1);
    localparam logic [CNT_W-1:0] FL_LAST  = CNT_W'(FIN_LONG - 1);
    localparam logic [CNT_W-1:0] RES_LAST = CNT_W'(RES_BITS - 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             lng;
    } seq_t;

    seq_t st_d, st_q;
    logic [CNT_W-1:0] fin_last;

    always_comb begin
        fin_last = st_q.lng ? FL_LAST : FS_LAST;
        st_d     = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (accept_i) begin
                    st_d.ph  = PH_BUF;
                    st_d.cnt = '0;
                    st_d.lng = long_i;
                end
            end
            PH_BUF: begin
                if (tick_i) begin
                    if (st_q.cnt == BUF_LAST) begin
                        st_d.ph  = PH_FINAL;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_FINAL: begin
                if (tick_i) begin
                    if (st_q.cnt == fin_last) begin
                        st_d.ph  = PH_RES;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick_i) begin
                    if (st_q.cnt == RES_LAST) begin
                        st_d.ph  = PH_IDLE;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0, lng: 1'b0};
        else        st_q <= st_d;
    end

    assign phase_o    = st_q.ph;
    assign cnt_o      = st_q.cnt;
    assign res_tick_o = (st_q.ph == PH_RES) && tick_i;
    assign finish_o   = (st_q.ph == PH_RES) && tick_i && (st_q.cnt == RES_LAST);

    // R2: leaving the buffered phase only after its last enabled cycle
    a_r2_buf_len: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_FINAL && $past(st_q.ph) == PH_BUF)
        |-> ($past(st_q.cnt) == BUF_LAST && $past(tick_i)));

    // R3: the direct phase lasts the length latched at start
    a_r3_final_len: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RES && $past(st_q.ph) == PH_FINAL)
        |-> ($past(st_q.cnt) == (st_q.lng ? FL_LAST : FS_LAST)));

    // R6: no progress without an enabled cycle
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != PH_IDLE && !tick_i) |=> ($stable(st_q.ph) && $stable(st_q.cnt)));
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
    parameter int RES_BITS = 10,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                in_res_i,
    input  logic                res_tick_i,
    input  logic                finish_i,
    input  logic [CNT_W-1:0]    cnt_i,
    input  logic                keep_i,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                done_o
);
    localparam logic [CNT_W-1:0]    TOP_IDX = CNT_W'(RES_BITS - 1);
    localparam logic [RES_BITS-1:0] MSB_ONE = RES_BITS'(1) << (RES_BITS - 1);

    typedef struct packed {
        logic [RES_BITS-1:0] acc;
        logic [RES_BITS-1:0] res;
        logic                done;
    } sar_t;

    sar_t st_d, st_q;
    logic [CNT_W-1:0]    idx;
    logic [RES_BITS-1:0] trial;

    always_comb begin
        idx   = TOP_IDX - cnt_i;
        trial = st_q.acc | (RES_BITS'(1) << idx);
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear_i) begin
            st_d.acc = '0;
        end else if (res_tick_i) begin
            if (keep_i) st_d.acc = trial;
            if (finish_i) begin
                st_d.res  = keep_i ? trial : st_q.acc;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dac_code_o = in_res_i ? trial : '0;
    assign result_o   = st_q.res;
    assign done_o     = st_q.done;

    // R8: completion pulse is a single clock wide
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: result only moves together with the completion pulse
    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R4: the first trial of every resolution is the top bit alone
    a_r4_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_res_i) |-> (dac_code_o == MSB_ONE));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
    parameter int RES_BITS  = 10,
    parameter int CHAN_W    = 5,
    parameter int NUM_EXT   = 16,
    parameter int BUF_CYC   = 2,
    parameter int FIN_SHORT = 2,
    parameter int FIN_LONG  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_en_i,
    input  logic                start_i,
    input  logic [CHAN_W-1:0]   chan_i,
    input  logic                long_samp_i,
    input  logic                cmp_i,
    output logic [CHAN_W-1:0]   ch_sel_o,
    output logic [1:0]          phase_o,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] result_o
);
    import sar_seq_pkg::*;

    localparam int MAX_LEN = (RES_BITS > FIN_LONG) ? RES_BITS : FIN_LONG;
    localparam int CNT_W   = $clog2(MAX_LEN) + 1;

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             res_tick, finish, accept, chan_ok, keep;

    assign accept = start_i && (phase == PH_IDLE);
    assign keep   = cmp_i && chan_ok;

    sar_chan_decode #(.CHAN_W(CHAN_W), .NUM_EXT(NUM_EXT)) u_dec (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .chan_i(chan_i),
        .ch_sel_o(ch_sel_o), .chan_ok_o(chan_ok)
    );

    sar_phase_ctrl #(
        .BUF_CYC(BUF_CYC), .FIN_SHORT(FIN_SHORT), .FIN_LONG(FIN_LONG),
        .RES_BITS(RES_BITS), .CNT_W(CNT_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .tick_i(conv_en_i), .accept_i(accept),
        .long_i(long_samp_i), .phase_o(phase), .cnt_o(cnt),
        .res_tick_o(res_tick), .finish_o(finish)
    );

    sar_approx #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .in_res_i(phase == PH_RES),
        .res_tick_i(res_tick), .finish_i(finish), .cnt_i(cnt), .keep_i(keep),
        .dac_code_o(dac_code_o), .result_o(result_o), .done_o(done_o)
    );

    assign phase_o = phase;
    assign busy_o  = (phase != PH_IDLE);

    // R1: an idle start enters the buffered phase on the next clock
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && phase_o == 2'b01));

    // R7: a start during a conversion leaves the channel untouched
    a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> $stable(ch_sel_o));

    // R10: unsupported channel codes complete with zero
    a_r10_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !chan_ok) |-> (result_o == '0));
endmodule

// File: tb/sar_conv_seq_test.sv
module sar_conv_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_en = 1'b1;
    logic       start = 1'b0;
    logic [4:0] chan = '0;
    logic       long_samp = 1'b0;
    logic       cmp;
    logic [4:0] ch_sel;
    logic [1:0] phase;
    logic [9:0] dac_code;
    logic       busy, done;
    logic [9:0] result;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [4:0] ch;
        logic [9:0] res;
        int         fin;
    } exp_t;
    exp_t exp_q[$];

    logic [4:0] cur_ch = '0;
    int         en_mode = 0;
    int         en_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_conv_seq uut (
        .clk(clk), .rst_n(rst_n), .conv_en_i(conv_en), .start_i(start),
        .chan_i(chan), .long_samp_i(long_samp), .cmp_i(cmp),
        .ch_sel_o(ch_sel), .phase_o(phase), .dac_code_o(dac_code),
        .busy_o(busy), .done_o(done), .result_o(result)
    );

    function automatic int aval(input logic [4:0] c);
        if (c < 5'd16)       return (int'(c) * 389 + 77) % 1024;
        else if (c == 5'd17) return 0;
        else if (c == 5'd18) return 1023;
        else if (c == 5'd19) return 512;
        else                 return 1023;
    endfunction

    function automatic logic [9:0] exp_res(input logic [4:0] c);
        if (c < 5'd16 || c == 5'd17 || c == 5'd18 || c == 5'd19) return 10'(aval(c));
        return 10'd0;
    endfunction

    assign cmp = (aval(cur_ch) >= int'(dac_code));

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: drives the enable, counts ticks per phase, scores results
    int         n_buf = 0, n_fin = 0, n_res = 0;
    logic [1:0] prev_ph = 2'b00;
    logic [9:0] last_res = '0;
    bit         hold_bad = 0;
    bit         want_low = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (want_low) begin
                check(!done, "R8 done one clock", int'(done), 0);
                want_low = 0;
            end
            if (done) begin
                exp_t e;
                want_low = 1;
                if (exp_q.size() == 0) begin
                    check(0, "R7 unexpected result", int'(result), -1);
                end else begin
                    e = exp_q.pop_front();
                    if (e.ch < 5'd16 || e.ch == 5'd17 || e.ch == 5'd18 || e.ch == 5'd19)
                        check(result == e.res, "R4/R9 result", int'(result), int'(e.res));
                    else
                        check(result == e.res, "R10 bad code zero", int'(result), int'(e.res));
                    check(n_buf == 2, "R2 buffered ticks", n_buf, 2);
                    check(n_fin == e.fin, "R3 direct ticks", n_fin, e.fin);
                    check(n_res == 10, "R4 resolution ticks", n_res, 10);
                    check(n_buf + n_fin + n_res == 4 + e.fin + 8, "R5 total ticks",
                          n_buf + n_fin + n_res, 4 + e.fin + 8);
                    check(!hold_bad, "R8 result held", int'(hold_bad), 0);
                end
                last_res = result;
                hold_bad = 0;
                n_buf = 0; n_fin = 0; n_res = 0;
            end else if (result != last_res) begin
                hold_bad = 1;
            end
            if (phase == 2'b11 && prev_ph != 2'b11)
                check(dac_code == 10'h200, "R4 msb first trial", int'(dac_code), 512);
            prev_ph = phase;
            en_cnt++;
            if (en_mode == 0) conv_en = 1'b1;
            else              conv_en = ((en_cnt % 3) == 0) || ((en_cnt % 7) == 2);
            if (conv_en) begin
                if (phase == 2'b01) n_buf++;
                if (phase == 2'b10) n_fin++;
                if (phase == 2'b11) n_res++;
            end
        end
    end

    task automatic convert(input logic [4:0] c, input bit lng, input bit poke);
        exp_t e;
        @(negedge clk);
        start = 1'b1; chan = c; long_samp = lng;
        cur_ch = c;
        e.ch = c; e.res = exp_res(c); e.fin = lng ? 8 : 2;
        exp_q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        check(busy && phase == 2'b01, "R1 accepted", int'(phase), 1);
        check(ch_sel == c, "R1 channel out", int'(ch_sel), int'(c));
        if (poke) begin
            while (phase != 2'b10) @(negedge clk);
            start = 1'b1; chan = c ^ 5'd5; long_samp = ~lng;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            check(ch_sel == c, "R7 busy start ignored", int'(ch_sel), int'(c));
        end
        while (exp_q.size() != 0 || busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(phase == 2'b00, "R11 reset phase", int'(phase), 0);
        check(!busy && !done, "R11 reset busy/done", int'(busy) + int'(done), 0);
        check(result == 10'd0, "R11 reset result", int'(result), 0);
        check(dac_code == 10'd0, "R11 reset dac", int'(dac_code), 0);

        convert(5'd5, 1'b0, 1'b0);
        convert(5'd12, 1'b1, 1'b0);
        convert(5'd17, 1'b0, 1'b0);   // R9 low reference
        convert(5'd18, 1'b1, 1'b0);   // R9 high reference
        convert(5'd19, 1'b0, 1'b0);   // R9 midpoint
        convert(5'd16, 1'b0, 1'b0);   // R10
        convert(5'd25, 1'b1, 1'b0);   // R10
        convert(5'd0, 1'b0, 1'b0);
        convert(5'd15, 1'b1, 1'b0);

        en_mode = 1;                   // R6 gapped enable
        convert(5'd3, 1'b1, 1'b0);
        convert(5'd9, 1'b0, 1'b0);
        convert(5'd7, 1'b0, 1'b1);     // R7 poke while busy
        en_mode = 0;
        convert(5'd11, 1'b1, 1'b1);

        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R7 no pending", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule